// File: doc/BRIEF.md
# FPU load/store dispatch controller

This block sits in front of the operand converter of a stack-based floating-point unit. For each memory-touching operation it takes a 5-bit operation index, the addressing mode and the segment access limit. It checks the operand size against the limit and sorts the index into one of four classes: no stack access, top register, push, or illegal. It then maintains the eight-entry tag word and the 3-bit top-of-stack pointer. It also handles control-word loads and stores and status-word stores internally.

Converter operations are started with a one-cycle pulse. The block waits for a done report that carries a success flag, a tag for loaded values and a C1 value. Only that report decides whether a store pops the stack and whether a float load backs its push out again. While a truncating integer store is in flight, the rounding field of the control word reads as chop. The field returns to its previous value when the store ends.

The operation index is the 3-bit reg field of the addressing byte followed by opcode bits 2 and 1. Tags are 2 bits per register: 00 valid, 01 zero, 10 special, 11 empty. Register i sits at `tagWord[2i+1:2i]`.

Top module: `fpu_ldst_ctrl`

## Requirements
- R1: An operation is accepted on a clock edge where `opValid` is high and `busy` is low. Converter operations raise `cvtStart` for exactly one cycle after acceptance, with `cvtIndex` equal to the accepted index. `busy` stays high until the edge where `cvtDone` is sampled high. Any `opValid` seen while `busy` is high is ignored.
- R2: With `protMode` high, the operation faults when `accessLimit` is below the operand size. Sizes for indices 0-15 are 4,4,8,2 repeating, except index 4, which has size 0. For indices 16-23 the sizes are A,0,B,10,2,10,0,8, and for indices 24-31 they are A,0,B,10,2,10,2,8. A=28 and B=108 when `seg32` is high; A=14 and B=94 otherwise. A fault pulses `segFault` and `opDone`, starts nothing and changes no state.
- R3: Indices 4, 17, 22 and 25 pulse `illegalOp` and `opDone`. They start nothing and change no state.
- R4: A push-class index (0-3, 19, 21, 23) finds the tag of register (top−1 mod 8) not empty. The block then pulses `stackOverflow` and `opDone`, and top, the tags and the converter stay untouched.
- R5: An accepted push decrements top on the accept edge. On done, the block writes `cvtTag` into the tag of the new top.
- R6: Indices 0 and 2 are float loads. For these only, a done with `cvtOk` low increments top again and leaves that tag empty. Other loads write the tag whatever `cvtOk` is.
- R7: Indices 5-7, 12-15, 27, 29 and 31 are the store-and-pop indices. When done comes with `cvtOk` high, they mark the top tag empty and increment top. With `cvtOk` low, or for the plain stores 8-11, top and the tags stay as they are.
- R8: Indices 5-7 are the truncating stores. While one of them is busy, `ctrlWord[11:10]` reads 11 (chop). After done, `ctrlWord` returns to its stored value.
- R9: Data operations are the push and top-register classes. A data operation clears C1 on accept and loads `cvtC1` into C1 on done. Control-word and status-word accesses leave C1 unchanged.
- R10: Index 20 loads `cwIn` into the control word and completes at once. The error-summary bit and the busy bit (`errSummary`, `fpBusyBit`) are set if `excFlags & ~ctrlWord[5:0]` is nonzero, and cleared otherwise.
- R11: With parameter `FORCE_CW_BIT6` set to 1, a control-word load always leaves bit 6 at 1.
- R12: Index 28 pulses `storeValid` with the control word on `storeData`. Index 30 pulses it with the status word. The status word is laid out as: bit 15 busy, bits 13:11 top, bit 9 C1, bit 7 summary, bits 5:0 `excFlags`, and all other bits 0.
- R13: Every accepted operation produces exactly one `opDone` pulse. At most one of `segFault`, `illegalOp` and `stackOverflow` is high, and only together with `opDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation request |
| opIndex | input | 5 | Operation index (reg field, opcode bits 2:1) |
| protMode | input | 1 | Protected addressing, enables limit check |
| seg32 | input | 1 | 32-bit segment size selects larger environment sizes |
| accessLimit | input | LIMIT_W | Bytes accessible at the operand address |
| cwIn | input | 16 | Control word read from memory for index 20 |
| excFlags | input | 6 | Exception flags of the status word |
| cvtDone | input | 1 | Converter finished |
| cvtOk | input | 1 | Value stored / load not aborted |
| cvtTag | input | 2 | Tag of loaded value |
| cvtC1 | input | 1 | C1 result from the converter |
| busy | output | 1 | Converter operation in flight |
| cvtStart | output | 1 | One-cycle converter start |
| cvtIndex | output | 5 | Index handed to the converter |
| segFault | output | 1 | Limit violation pulse |
| illegalOp | output | 1 | Illegal index pulse |
| stackOverflow | output | 1 | Push blocked pulse |
| opDone | output | 1 | Operation complete pulse |
| storeValid | output | 1 | storeData valid pulse |
| storeData | output | 16 | Control or status word to memory |
| topPtr | output | PTR_W | Top-of-stack pointer |
| tagWord | output | 2*NREG | Tags, register i at bits 2i+1:2i |
| ctrlWord | output | 16 | Effective control word |
| c1Bit | output | 1 | Condition bit C1 |
| errSummary | output | 1 | Error-summary bit |
| fpBusyBit | output | 1 | Status-word busy bit |

## Verification
A corrupted top pointer shows on `topPtr` at the next clock edge. It also shows one operation later as a wrong overflow decision, or as a tag written into the wrong slot of `tagWord`. A stuck control state shows as `busy` failing to fall on the cycle after `cvtDone`, or as a second `cvtStart`. A wrong chop or restore shows on `ctrlWord` within the same cycle. Errors in the summary or C1 bits reach `storeData` on the next status-word store.

// File: rtl/fpu_ldst_pkg.sv
package fpu_ldst_pkg;

  typedef enum logic [1:0] {CLS_NONE, CLS_REG0, CLS_PUSH, CLS_ILL} opClass_e;

  localparam int SIZE_W = 7;
  localparam logic [1:0] TAG_EMPTY = 2'b11;
  localparam logic [4:0] IDX_CW_LOAD  = 5'd20;
  localparam logic [4:0] IDX_CW_STORE = 5'd28;
  localparam logic [4:0] IDX_SW_STORE = 5'd30;
  localparam logic [15:0] CW_RESET = 16'h037F;
  localparam logic [15:0] RC_CHOP  = 16'h0C00;

  // strobes from the control FSM to the datapath, applied on the same edge
  typedef struct packed {
    logic       topDec;
    logic       topInc;
    logic       tagWr;
    logic [1:0] tagVal;
    logic       c1Wr;
    logic       c1Val;
    logic       cwLoad;
    logic       storeCw;
    logic       storeSw;
  } dpStrobe_t;

  function automatic opClass_e classOf(input logic [4:0] idx);
    opClass_e c;
    if (!idx[4]) begin
      if (idx[3:2] == 2'b00) c = CLS_PUSH;
      else if (idx == 5'd4)  c = CLS_ILL;
      else                   c = CLS_REG0;
    end else begin
      case (idx[3:0])
        4'd1, 4'd6, 4'd9:    c = CLS_ILL;
        4'd3, 4'd5, 4'd7:    c = CLS_PUSH;
        4'd11, 4'd13, 4'd15: c = CLS_REG0;
        default:             c = CLS_NONE;
      endcase
    end
    return c;
  endfunction

  function automatic logic [SIZE_W-1:0] sizeOf(input logic [4:0] idx, input logic wide);
    logic [SIZE_W-1:0] s;
    if (!idx[4]) begin
      if (idx == 5'd4) s = '0;
      else case (idx[1:0])
        2'd0, 2'd1: s = 7'd4;
        2'd2:       s = 7'd8;
        default:    s = 7'd2;
      endcase
    end else begin
      case (idx[2:0])
        3'd0:    s = wide ? 7'd28 : 7'd14;
        3'd1:    s = '0;
        3'd2:    s = wide ? 7'd108 : 7'd94;
        3'd3:    s = 7'd10;
        3'd4:    s = 7'd2;
        3'd5:    s = 7'd10;
        3'd6:    s = idx[3] ? 7'd2 : 7'd0;
        default: s = 7'd8;
      endcase
    end
    return s;
  endfunction

  function automatic logic popsOnStore(input logic [4:0] idx);
    if (!idx[4]) return (idx[3:2] == 2'b11) || (idx[3:2] == 2'b01 && idx[1:0] != 2'b00);
    return idx[3] && idx[0] && (idx[2:1] != 2'b00);
  endfunction

  function automatic logic isFloatLoad(input logic [4:0] idx);
    return (idx == 5'd0) || (idx == 5'd2);
  endfunction

  function automatic logic isTruncStore(input logic [4:0] idx);
    return (idx[4:2] == 3'b001) && (idx[1:0] != 2'b00);
  endfunction

endpackage

// File: rtl/fpu_ldst_ctl.sv
module fpu_ldst_ctl
  import fpu_ldst_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               opValid,
  input  logic [4:0]         opIndex,
  input  logic               protMode,
  input  logic               seg32,
  input  logic [LIMIT_W-1:0] accessLimit,
  input  logic               pushSlotEmpty,
  input  logic               cvtDone,
  input  logic               cvtOk,
  input  logic [1:0]         cvtTag,
  input  logic               cvtC1,
  output dpStrobe_t          stb,
  output logic               chopActive,
  output logic               busy,
  output logic               cvtStart,
  output logic [4:0]         cvtIndex,
  output logic               segFault,
  output logic               illegalOp,
  output logic               stackOverflow,
  output logic               opDone
);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e     state, stateNxt;
  logic [4:0] curIdx;
  opClass_e   reqCls, curCls;
  logic       limitFault, startNow, doneNow, faultNow, illNow, ovfNow;

  assign reqCls     = classOf(opIndex);
  assign curCls     = classOf(curIdx);
  assign limitFault = protMode && (accessLimit < LIMIT_W'(sizeOf(opIndex, seg32)));

  always_comb begin
    stb      = '0;
    stateNxt = state;
    startNow = 1'b0;
    doneNow  = 1'b0;
    faultNow = 1'b0;
    illNow   = 1'b0;
    ovfNow   = 1'b0;
    if (state == ST_IDLE) begin
      if (opValid) begin
        if (limitFault) faultNow = 1'b1;
        else begin
          case (reqCls)
            CLS_ILL: illNow = 1'b1;
            CLS_PUSH: begin
              if (!pushSlotEmpty) ovfNow = 1'b1;
              else begin
                stb.topDec = 1'b1;
                stb.c1Wr   = 1'b1;
                startNow   = 1'b1;
              end
            end
            CLS_REG0: begin
              stb.c1Wr = 1'b1;
              startNow = 1'b1;
            end
            default: begin
              if (opIndex == IDX_CW_LOAD)       stb.cwLoad  = 1'b1;
              else if (opIndex == IDX_CW_STORE) stb.storeCw = 1'b1;
              else if (opIndex == IDX_SW_STORE) stb.storeSw = 1'b1;
              else                              startNow    = 1'b1;
            end
          endcase
        end
        doneNow = !startNow;
        if (startNow) stateNxt = ST_WAIT;
      end
    end else if (cvtDone) begin
      doneNow  = 1'b1;
      stateNxt = ST_IDLE;
      if (curCls == CLS_PUSH) begin
        if (isFloatLoad(curIdx) && !cvtOk) stb.topInc = 1'b1;
        else begin
          stb.tagWr  = 1'b1;
          stb.tagVal = cvtTag;
        end
      end
      if (popsOnStore(curIdx) && cvtOk) begin
        stb.tagWr  = 1'b1;
        stb.tagVal = TAG_EMPTY;
        stb.topInc = 1'b1;
      end
      if (curCls != CLS_NONE) begin
        stb.c1Wr  = 1'b1;
        stb.c1Val = cvtC1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      curIdx        <= '0;
      cvtStart      <= 1'b0;
      segFault      <= 1'b0;
      illegalOp     <= 1'b0;
      stackOverflow <= 1'b0;
      opDone        <= 1'b0;
    end else begin
      state         <= stateNxt;
      if (state == ST_IDLE && opValid) curIdx <= opIndex;
      cvtStart      <= startNow;
      segFault      <= faultNow;
      illegalOp     <= illNow;
      stackOverflow <= ovfNow;
      opDone        <= doneNow;
    end
  end

  assign busy       = (state == ST_WAIT);
  assign chopActive = busy && isTruncStore(curIdx);
  assign cvtIndex   = curIdx;

endmodule

// File: rtl/fpu_ldst_dp.sv
module fpu_ldst_dp
  import fpu_ldst_pkg::*;
#(
  parameter int NREG          = 8,
  parameter bit FORCE_CW_BIT6 = 1'b0,
  localparam int PTR_W        = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         stb,
  input  logic              chopActive,
  input  logic [15:0]       cwIn,
  input  logic [5:0]        excFlags,
  output logic              pushSlotEmpty,
  output logic [PTR_W-1:0]  topPtr,
  output logic [2*NREG-1:0] tagWord,
  output logic [15:0]       ctrlWord,
  output logic              c1Bit,
  output logic              errSummary,
  output logic              fpBusyBit,
  output logic              storeValid,
  output logic [15:0]       storeData
);

  logic [1:0]  tags [NREG];
  logic [15:0] cwReg, cwLoaded, statusWord;
  logic        unmasked;

  assign cwLoaded = FORCE_CW_BIT6 ? (cwIn | 16'h0040) : cwIn;
  assign unmasked = |(excFlags & ~cwLoaded[5:0]);
  assign pushSlotEmpty = (tags[PTR_W'(topPtr - 1'b1)] == TAG_EMPTY);
  assign ctrlWord = chopActive ? (cwReg | RC_CHOP) : cwReg;
  assign statusWord = {fpBusyBit, 1'b0, 3'(topPtr), 1'b0, c1Bit, 1'b0,
                       errSummary, 1'b0, excFlags};

  for (genvar g = 0; g < NREG; g++) begin : g_tag
    assign tagWord[2*g +: 2] = tags[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      topPtr     <= '0;
      for (int i = 0; i < NREG; i++) tags[i] <= TAG_EMPTY;
      cwReg      <= CW_RESET;
      c1Bit      <= 1'b0;
      errSummary <= 1'b0;
      fpBusyBit  <= 1'b0;
      storeValid <= 1'b0;
      storeData  <= '0;
    end else begin
      storeValid <= stb.storeCw | stb.storeSw;
      if (stb.storeCw) storeData <= cwReg;
      else if (stb.storeSw) storeData <= statusWord;
      if (stb.tagWr) tags[topPtr] <= stb.tagVal;
      if (stb.topDec) topPtr <= topPtr - 1'b1;
      else if (stb.topInc) topPtr <= topPtr + 1'b1;
      if (stb.c1Wr) c1Bit <= stb.c1Val;
      if (stb.cwLoad) begin
        cwReg      <= cwLoaded;
        errSummary <= unmasked;
        fpBusyBit  <= unmasked;
      end
    end
  end

endmodule

// File: rtl/fpu_ldst_ctrl.sv
module fpu_ldst_ctrl
  import fpu_ldst_pkg::*;
#(
  parameter int NREG          = 8,
  parameter int LIMIT_W       = 16,
  parameter bit FORCE_CW_BIT6 = 1'b0,
  localparam int PTR_W        = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               opValid,
  input  logic [4:0]         opIndex,
  input  logic               protMode,
  input  logic               seg32,
  input  logic [LIMIT_W-1:0] accessLimit,
  input  logic [15:0]        cwIn,
  input  logic [5:0]         excFlags,
  input  logic               cvtDone,
  input  logic               cvtOk,
  input  logic [1:0]         cvtTag,
  input  logic               cvtC1,
  output logic               busy,
  output logic               cvtStart,
  output logic [4:0]         cvtIndex,
  output logic               segFault,
  output logic               illegalOp,
  output logic               stackOverflow,
  output logic               opDone,
  output logic               storeValid,
  output logic [15:0]        storeData,
  output logic [PTR_W-1:0]   topPtr,
  output logic [2*NREG-1:0]  tagWord,
  output logic [15:0]        ctrlWord,
  output logic               c1Bit,
  output logic               errSummary,
  output logic               fpBusyBit
);

  dpStrobe_t stb;
  logic      chopActive, pushSlotEmpty;

  fpu_ldst_ctl #(.LIMIT_W(LIMIT_W)) ctl_i (
    .clk, .rst_n, .opValid, .opIndex, .protMode, .seg32, .accessLimit,
    .pushSlotEmpty, .cvtDone, .cvtOk, .cvtTag, .cvtC1,
    .stb, .chopActive, .busy, .cvtStart, .cvtIndex,
    .segFault, .illegalOp, .stackOverflow, .opDone
  );

  fpu_ldst_dp #(.NREG(NREG), .FORCE_CW_BIT6(FORCE_CW_BIT6)) dp_i (
    .clk, .rst_n, .stb, .chopActive, .cwIn, .excFlags,
    .pushSlotEmpty, .topPtr, .tagWord, .ctrlWord, .c1Bit,
    .errSummary, .fpBusyBit, .storeValid, .storeData
  );

endmodule

// File: rtl/fpu_ldst_chk.sv
module fpu_ldst_chk #(
  parameter int NREG  = 8,
  parameter int PTR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cvtStart,
  input logic              cvtDone,
  input logic              segFault,
  input logic              illegalOp,
  input logic              stackOverflow,
  input logic              opDone,
  input logic [PTR_W-1:0]  topPtr,
  input logic [2*NREG-1:0] tagWord
);

  a_r1_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cvtStart |=> !cvtStart);

  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cvtStart |-> busy);

  a_r2_fault_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    segFault |-> (topPtr == $past(topPtr)) && (tagWord == $past(tagWord)));

  a_r4_no_overflow_move: assert property (@(posedge clk) disable iff (!rst_n)
    stackOverflow |-> $stable(topPtr) && $stable(tagWord));

  a_r7_pop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && (topPtr != $past(topPtr))) |-> $past(cvtDone));

  a_r13_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({segFault, illegalOp, stackOverflow}));

  a_r13_error_done: assert property (@(posedge clk) disable iff (!rst_n)
    (segFault || illegalOp || stackOverflow) |-> opDone);

endmodule

bind fpu_ldst_ctrl fpu_ldst_chk #(.NREG(NREG), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cvtStart(cvtStart), .cvtDone(cvtDone),
  .segFault(segFault), .illegalOp(illegalOp), .stackOverflow(stackOverflow),
  .opDone(opDone), .topPtr(topPtr), .tagWord(tagWord)
);

// File: tb/fpu_ldst_ctrl_tb_top.sv
module fpu_ldst_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opIndex = '0;
  logic        protMode = 1'b0;
  logic        seg32 = 1'b0;
  logic [15:0] accessLimit = '0;
  logic [15:0] cwIn = '0;
  logic [5:0]  excFlags = '0;
  logic        cvtDone = 1'b0;
  logic        cvtOk = 1'b0;
  logic [1:0]  cvtTag = '0;
  logic        cvtC1 = 1'b0;

  logic        busy, cvtStart, segFault, illegalOp, stackOverflow, opDone, storeValid;
  logic [4:0]  cvtIndex;
  logic [15:0] storeData, ctrlWord, tagWord;
  logic [2:0]  topPtr;
  logic        c1Bit, errSummary, fpBusyBit;

  logic        busyB, cvtStartB, segFaultB, illegalOpB, stackOverflowB, opDoneB, storeValidB;
  logic [4:0]  cvtIndexB;
  logic [15:0] storeDataB, ctrlWordB, tagWordB;
  logic [2:0]  topPtrB;
  logic        c1BitB, errSummaryB, fpBusyBitB;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_ldst_ctrl dut_i (
    .clk, .rst_n, .opValid, .opIndex, .protMode, .seg32, .accessLimit, .cwIn,
    .excFlags, .cvtDone, .cvtOk, .cvtTag, .cvtC1, .busy, .cvtStart, .cvtIndex,
    .segFault, .illegalOp, .stackOverflow, .opDone, .storeValid, .storeData,
    .topPtr, .tagWord, .ctrlWord, .c1Bit, .errSummary, .fpBusyBit
  );

  fpu_ldst_ctrl #(.FORCE_CW_BIT6(1'b1)) dut6_i (
    .clk, .rst_n, .opValid, .opIndex, .protMode, .seg32, .accessLimit, .cwIn,
    .excFlags, .cvtDone, .cvtOk, .cvtTag, .cvtC1, .busy(busyB), .cvtStart(cvtStartB),
    .cvtIndex(cvtIndexB), .segFault(segFaultB), .illegalOp(illegalOpB),
    .stackOverflow(stackOverflowB), .opDone(opDoneB), .storeValid(storeValidB),
    .storeData(storeDataB), .topPtr(topPtrB), .tagWord(tagWordB), .ctrlWord(ctrlWordB),
    .c1Bit(c1BitB), .errSummary(errSummaryB), .fpBusyBit(fpBusyBitB)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge; returns at the next falling edge with accept-edge results visible
  task automatic issue(input logic [4:0] idx);
    @(negedge clk);
    opIndex = idx;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic complete(input logic ok, input logic [1:0] tag, input logic c1);
    cvtOk = ok; cvtTag = tag; cvtC1 = c1; cvtDone = 1'b1;
    @(negedge clk);
    cvtDone = 1'b0;
  endtask

  task automatic tReset();
    check("R1 reset busy", 32'(busy), 0);
    check("R5 reset top", 32'(topPtr), 0);
    check("R5 reset tags", 32'(tagWord), 32'hFFFF);
    check("R8 reset cw", 32'(ctrlWord), 32'h037F);
    check("R9 reset c1", 32'(c1Bit), 0);
  endtask

  task automatic tLoadPush();
    issue(5'd1);
    check("R1 start", 32'(cvtStart), 1);
    check("R1 index", 32'(cvtIndex), 1);
    check("R5 top dec", 32'(topPtr), 7);
    @(negedge clk);
    opIndex = 5'd28; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    check("R1 ignored while busy store", 32'(storeValid), 0);
    check("R1 ignored while busy start", 32'(cvtStart), 0);
    check("R1 still busy", 32'(busy), 1);
    complete(1'b1, 2'b00, 1'b1);
    check("R13 done", 32'(opDone), 1);
    check("R5 tag written", 32'(tagWord[15:14]), 0);
    check("R5 top kept", 32'(topPtr), 7);
    check("R9 c1 from converter", 32'(c1Bit), 1);
    check("R1 idle", 32'(busy), 0);
  endtask

  task automatic tCtrlAccess();
    issue(5'd28);
    check("R12 cw store valid", 32'(storeValid), 1);
    check("R12 cw store data", 32'(storeData), 32'h037F);
    check("R9 c1 kept by cw store", 32'(c1Bit), 1);
    check("R13 cw store done", 32'(opDone), 1);
    issue(5'd30);
    check("R12 sw store data", 32'(storeData), 32'h3A00);
  endtask

  task automatic tStorePop();
    issue(5'd9);
    check("R9 c1 cleared on accept", 32'(c1Bit), 0);
    complete(1'b1, 2'b00, 1'b0);
    check("R7 plain store no pop", 32'(topPtr), 7);
    issue(5'd13);
    complete(1'b0, 2'b00, 1'b0);
    check("R7 failed store no pop top", 32'(topPtr), 7);
    check("R7 failed store no pop tag", 32'(tagWord[15:14]), 0);
    issue(5'd13);
    complete(1'b1, 2'b00, 1'b0);
    check("R7 pop top", 32'(topPtr), 0);
    check("R7 pop tag", 32'(tagWord[15:14]), 3);
  endtask

  task automatic tChop();
    issue(5'd3);
    complete(1'b1, 2'b01, 1'b0);
    check("R5 zero tag", 32'(tagWord[15:14]), 1);
    issue(5'd6);
    check("R8 chop during store", 32'(ctrlWord), 32'h0F7F);
    complete(1'b1, 2'b00, 1'b0);
    check("R8 restored", 32'(ctrlWord), 32'h037F);
    check("R7 trunc pop", 32'(topPtr), 0);
    issue(5'd11);
    check("R8 no chop plain", 32'(ctrlWord), 32'h037F);
    complete(1'b0, 2'b00, 1'b0);
  endtask

  task automatic tNanUndo();
    issue(5'd0);
    check("R5 float push", 32'(topPtr), 7);
    complete(1'b0, 2'b10, 1'b0);
    check("R6 undo top", 32'(topPtr), 0);
    check("R6 tag empty", 32'(tagWord[15:14]), 3);
    issue(5'd2);
    complete(1'b0, 2'b10, 1'b0);
    check("R6 undo 64-bit", 32'(topPtr), 0);
    issue(5'd3);
    complete(1'b0, 2'b10, 1'b0);
    check("R6 int load keeps push", 32'(topPtr), 7);
    check("R6 int load tag", 32'(tagWord[15:14]), 2);
    issue(5'd15);
    complete(1'b1, 2'b00, 1'b0);
    check("R7 pop after int", 32'(topPtr), 0);
  endtask

  task automatic tOverflow();
    for (int i = 0; i < 8; i++) begin
      issue(5'd21);
      complete(1'b1, 2'b00, 1'b0);
    end
    check("R5 full stack tags", 32'(tagWord), 0);
    issue(5'd23);
    check("R4 overflow", 32'(stackOverflow), 1);
    check("R4 no start", 32'(cvtStart), 0);
    check("R4 top kept", 32'(topPtr), 0);
    check("R13 overflow done", 32'(opDone), 1);
    for (int i = 0; i < 8; i++) begin
      issue(5'd29);
      complete(1'b1, 2'b00, 1'b0);
    end
    check("R7 emptied", 32'(tagWord), 32'hFFFF);
  endtask

  task automatic tIllegal();
    logic [4:0] ill [4] = '{5'd4, 5'd17, 5'd22, 5'd25};
    for (int i = 0; i < 4; i++) begin
      issue(ill[i]);
      check("R3 illegal", 32'(illegalOp), 1);
      check("R3 no start", 32'(cvtStart), 0);
      check("R3 top kept", 32'(topPtr), 0);
      check("R3 tags kept", 32'(tagWord), 32'hFFFF);
    end
  endtask

  task automatic tSegLimit();
    protMode = 1'b1; seg32 = 1'b1;
    accessLimit = 16'd107; issue(5'd18);
    check("R2 32-bit restore fault", 32'(segFault), 1);
    check("R2 no start", 32'(cvtStart), 0);
    accessLimit = 16'd108; issue(5'd18);
    check("R2 32-bit restore ok", 32'(cvtStart), 1);
    complete(1'b1, 2'b00, 1'b0);
    accessLimit = 16'd100; issue(5'd26);
    check("R2 save fault", 32'(segFault), 1);
    seg32 = 1'b0;
    accessLimit = 16'd93; issue(5'd18);
    check("R2 16-bit restore fault", 32'(segFault), 1);
    accessLimit = 16'd94; issue(5'd18);
    check("R2 16-bit restore ok", 32'(segFault), 0);
    complete(1'b1, 2'b00, 1'b0);
    accessLimit = 16'd13; issue(5'd16);
    check("R2 16-bit env fault", 32'(segFault), 1);
    accessLimit = 16'd7; issue(5'd2);
    check("R2 load fault", 32'(segFault), 1);
    check("R2 no push", 32'(topPtr), 0);
    accessLimit = 16'd0; issue(5'd4);
    check("R2 size zero not fault", 32'(segFault), 0);
    check("R3 illegal under prot", 32'(illegalOp), 1);
    accessLimit = 16'd1; issue(5'd30);
    check("R2 sw store fault", 32'(storeValid), 0);
    accessLimit = 16'd2; issue(5'd30);
    check("R2 sw store ok", 32'(storeValid), 1);
    protMode = 1'b0;
  endtask

  task automatic tCwLoad();
    excFlags = 6'b000100; cwIn = 16'h0000;
    issue(5'd20);
    check("R10 cw loaded", 32'(ctrlWord), 0);
    check("R10 summary set", 32'(errSummary), 1);
    check("R10 busy set", 32'(fpBusyBit), 1);
    check("R11 bit6 forced", 32'(ctrlWordB), 32'h0040);
    issue(5'd30);
    check("R12 sw with summary", 32'(storeData), 32'h8084);
    cwIn = 16'h037F;
    issue(5'd20);
    check("R10 summary clear", 32'(errSummary), 0);
    check("R10 busy clear", 32'(fpBusyBit), 0);
    check("R11 bit6 kept", 32'(ctrlWordB), 32'h037F);
  endtask

  task automatic wrapUp();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tLoadPush();
    tCtrlAccess();
    tStorePop();
    tChop();
    tNanUndo();
    tOverflow();
    tIllegal();
    tSegLimit();
    tCwLoad();
    wrapUp();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrapUp();
  end

endmodule